// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns a mode code, one or two register selects and a signed displacement into the byte address of a memory operand. It holds a small file of 32-bit general registers, reads the base (and, in the indexed mode, a second index register), forms the address and presents it, registered, one clock after a start request together with a single-cycle valid strobe.

Four address forms are supported: base plus displacement, base plus index plus displacement, pre-decrement and post-increment. The two auto-modifying forms step the base register by the 4-byte processor word and write the modified value back into the register file at the same clock edge that registers the address. A load port presets registers, and a peek port reads any register combinationally, so that write-back results can be observed. Mode codes outside the four legal values raise an illegal-mode flag alongside the strobe and modify nothing.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset `ea_valid` and `bad_mode` are 0, `ea` is 0 and every register reads 0 on the peek port.
- R2: With `ld_en` high at a clock edge, register `ld_sel` takes `ld_data`, visible on `rd_data` after that edge.
- R3: Mode code 3'b000 (displaced) gives `ea` = base + displacement; no register changes.
- R4: Mode code 3'b001 (indexed) gives `ea` = base + index + displacement; no register changes.
- R5: Mode code 3'b010 (pre-decrement) gives `ea` = base - 4, and the base register holds base - 4 afterwards.
- R6: Mode code 3'b011 (post-increment) gives `ea` = base unchanged, and the base register holds base + 4 afterwards.
- R7: `ea_valid` is high in exactly the cycle after each cycle with `start` high and low otherwise; `ea` is registered at that edge.
- R8: Mode codes 3'b100 to 3'b111 give `bad_mode` = 1 with `ea_valid`, `ea` = 0, and no register changes.
- R9: The displacement is sign-extended to 32 bits and all address arithmetic wraps modulo 2^32.
- R10: When a load and a write-back target the same register at the same edge, the loaded value is kept.
- R11: Starts on consecutive cycles each see the register values left by the previous one (two post-increments issue addresses 4 apart).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register to load |
| ld_data | input | 32 | Value to load |
| rd_sel | input | 3 | Register shown on the peek port |
| rd_data | output | 32 | Combinational contents of register `rd_sel` |
| start | input | 1 | Request an address computation this cycle |
| mode | input | 3 | Address form code |
| base_sel | input | 3 | Base register select |
| idx_sel | input | 3 | Index register select (indexed form only) |
| disp | input | 16 | Signed displacement |
| ea | output | 32 | Registered effective address |
| ea_valid | output | 1 | One-cycle strobe marking `ea` |
| bad_mode | output | 1 | Illegal mode code flag, with `ea_valid` |

## Verification
The bound checker watches, every cycle, the strobe's one-cycle relation to `start`, that the illegal flag only appears with the strobe and a zero address, and that each legal form's address matches the register values sampled at the request. What those properties cannot show is the register file after write-back, the load-over-write-back priority and chains of back-to-back auto-modifying requests; the bench covers those through the peek port against its own register model, with directed cases at the wrap boundaries and negative displacements plus a seeded random mix of all eight codes.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int unsigned XLEN_DEF   = 32;
    localparam int unsigned NREGS_DEF  = 8;
    localparam int unsigned DISP_W_DEF = 16;
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [2:0] {
        MODE_DISP    = 3'd0,
        MODE_INDEX   = 3'd1,
        MODE_PREDEC  = 3'd2,
        MODE_POSTINC = 3'd3
    } eag_mode_e;

    function automatic logic mode_legal(input logic [2:0] m);
        return (m == MODE_DISP) || (m == MODE_INDEX) ||
               (m == MODE_PREDEC) || (m == MODE_POSTINC);
    endfunction

    function automatic logic mode_writes_back(input logic [2:0] m);
        return (m == MODE_PREDEC) || (m == MODE_POSTINC);
    endfunction

endpackage

// File: rtl/eag_regfile.sv
module eag_regfile #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 8,
    localparam int unsigned SEL_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [XLEN-1:0]  ld_data,
    input  logic             wb_en,
    input  logic [SEL_W-1:0] wb_sel,
    input  logic [XLEN-1:0]  wb_data,
    input  logic [SEL_W-1:0] ra_sel,
    output logic [XLEN-1:0]  ra_data,
    input  logic [SEL_W-1:0] rb_sel,
    output logic [XLEN-1:0]  rb_data,
    input  logic [SEL_W-1:0] rc_sel,
    output logic [XLEN-1:0]  rc_data
);

    logic [XLEN-1:0] regs_q [NREGS];

    // Write-back first, load afterwards: the later assignment wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            if (wb_en) regs_q[wb_sel] <= wb_data;
            if (ld_en) regs_q[ld_sel] <= ld_data;
        end
    end

    assign ra_data = regs_q[ra_sel];
    assign rb_data = regs_q[rb_sel];
    assign rc_data = regs_q[rc_sel];

endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned DISP_W = 16
) (
    input  logic [2:0]        mode,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   idx_val,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   addr,
    output logic              wb_req,
    output logic [XLEN-1:0]   wb_val,
    output logic              illegal
);

    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] disp_x;
    assign disp_x = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};

    always_comb begin
        addr    = '0;
        wb_val  = base_val;
        wb_req  = mode_writes_back(mode);
        illegal = !mode_legal(mode);
        case (mode)
            MODE_DISP:    addr = base_val + disp_x;
            MODE_INDEX:   addr = base_val + idx_val + disp_x;
            MODE_PREDEC: begin
                addr   = base_val - STEP;
                wb_val = base_val - STEP;
            end
            MODE_POSTINC: begin
                addr   = base_val;
                wb_val = base_val + STEP;
            end
            default:      addr = '0;
        endcase
    end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int unsigned XLEN   = XLEN_DEF,
    parameter int unsigned NREGS  = NREGS_DEF,
    parameter int unsigned DISP_W = DISP_W_DEF,
    localparam int unsigned SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [XLEN-1:0]   rd_data,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [SEL_W-1:0]  idx_sel,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   ea,
    output logic              ea_valid,
    output logic              bad_mode
);

    logic [XLEN-1:0] base_val, idx_val, calc_addr, calc_wb_val;
    logic            calc_wb_req, calc_illegal;

    eag_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .wb_en   (start && calc_wb_req),
        .wb_sel  (base_sel),
        .wb_data (calc_wb_val),
        .ra_sel  (base_sel),
        .ra_data (base_val),
        .rb_sel  (idx_sel),
        .rb_data (idx_val),
        .rc_sel  (rd_sel),
        .rc_data (rd_data)
    );

    eag_addr_calc #(.XLEN(XLEN), .DISP_W(DISP_W)) u_calc (
        .mode     (mode),
        .base_val (base_val),
        .idx_val  (idx_val),
        .disp     (disp),
        .addr     (calc_addr),
        .wb_req   (calc_wb_req),
        .wb_val   (calc_wb_val),
        .illegal  (calc_illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea       <= '0;
            ea_valid <= 1'b0;
            bad_mode <= 1'b0;
        end else begin
            ea_valid <= start;
            bad_mode <= start && calc_illegal;
            if (start) ea <= calc_addr;
        end
    end

endmodule

module eag_checker #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned DISP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        mode,
    input logic [DISP_W-1:0] disp,
    input logic [XLEN-1:0]   base_val,
    input logic [XLEN-1:0]   idx_val,
    input logic [XLEN-1:0]   ea,
    input logic              ea_valid,
    input logic              bad_mode
);

    logic [XLEN-1:0] dx;
    assign dx = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};

    // R7
    valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> ea_valid);
    // R7
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !ea_valid);
    // R8
    bad_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        bad_mode |-> (ea_valid && ea == '0));
    // R8
    bad_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode[2]) |=> bad_mode);
    // R3 R9
    disp_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd0) |=> (ea == $past(base_val + dx) && !bad_mode));
    // R4 R9
    index_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd1) |=> (ea == $past(base_val + idx_val + dx)));
    // R5
    predec_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd2) |=> (ea == $past(base_val) - XLEN'(4)));
    // R6
    postinc_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd3) |=> (ea == $past(base_val)));

endmodule

bind eff_addr_gen eag_checker #(.XLEN(XLEN), .DISP_W(DISP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .disp     (disp),
    .base_val (base_val),
    .idx_val  (idx_val),
    .ea       (ea),
    .ea_valid (ea_valid),
    .bad_mode (bad_mode)
);

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  base_sel = '0;
    logic [2:0]  idx_sel = '0;
    logic [15:0] disp = '0;
    logic [31:0] ea;
    logic        ea_valid;
    logic        bad_mode;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] model [8];

    always #10 clk = ~clk;

    eff_addr_gen dut (
        .clk, .rst, .ld_en, .ld_sel, .ld_data, .rd_sel, .rd_data,
        .start, .mode, .base_sel, .idx_sel, .disp, .ea, .ea_valid, .bad_mode
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    // Expected results from the requirement text.
    task automatic expect_op(input logic [2:0] m, input logic [31:0] b,
                             input logic [31:0] i, input logic [15:0] d,
                             output logic [31:0] e, output bit wb,
                             output logic [31:0] wv, output bit bad);
        wb = 0; wv = b; bad = 0; e = 32'h0;
        case (m)
            3'd0: e = b + sx(d);
            3'd1: e = b + i + sx(d);
            3'd2: begin e = b - 32'd4; wb = 1; wv = b - 32'd4; end
            3'd3: begin e = b; wb = 1; wv = b + 32'd4; end
            default: bad = 1;
        endcase
    endtask

    task automatic peek(input logic [2:0] s, input string req);
        rd_sel = s;
        #1;
        chk(rd_data === model[s], req, rd_data, model[s]);
    endtask

    // Called at a negedge; returns at the next negedge with start low.
    task automatic op(input logic [2:0] m, input logic [2:0] b, input logic [2:0] i,
                      input logic [15:0] d, input string req,
                      input bit ld = 0, input logic [2:0] ls = 0,
                      input logic [31:0] lv = 0);
        logic [31:0] e, wv;
        bit wb, bad;
        expect_op(m, model[b], model[i], d, e, wb, wv, bad);
        start = 1; mode = m; base_sel = b; idx_sel = i; disp = d;
        ld_en = ld; ld_sel = ls; ld_data = lv;
        @(posedge clk);
        @(negedge clk);
        start = 0; ld_en = 0;
        if (wb) model[b] = wv;
        if (ld) model[ls] = lv;
        chk(ea_valid === 1'b1, {req, " valid R7"}, 32'(ea_valid), 32'd1);
        chk(bad_mode === bad, {req, " bad_mode"}, 32'(bad_mode), 32'(bad));
        chk(ea === e, {req, " ea"}, ea, e);
        peek(b, {req, " base after"});
    endtask

    task automatic load(input logic [2:0] s, input logic [31:0] v);
        ld_en = 1; ld_sel = s; ld_data = v;
        @(posedge clk);
        @(negedge clk);
        ld_en = 0;
        model[s] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd24680));
        for (int k = 0; k < 8; k++) model[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(ea_valid === 1'b0, "R1 valid", 32'(ea_valid), 0);
        chk(bad_mode === 1'b0, "R1 bad_mode", 32'(bad_mode), 0);
        chk(ea === 32'h0, "R1 ea", ea, 0);
        for (int k = 0; k < 8; k++) peek(3'(k), "R1 regs");

        // R2 load port
        load(3'd1, 32'd1800);
        load(3'd2, 32'd3800);
        peek(3'd1, "R2 load r1");
        peek(3'd2, "R2 load r2");

        // R3 displaced, R4 indexed
        op(3'd0, 3'd2, 3'd0, 16'd100, "R3 disp 3900");
        chk(ea === 32'd3900, "R3 literal", ea, 32'd3900);
        op(3'd1, 3'd1, 3'd2, 16'd20, "R4 index 5620");
        chk(ea === 32'd5620, "R4 literal", ea, 32'd5620);
        // R5 pre-decrement
        op(3'd2, 3'd2, 3'd0, 16'd0, "R5 predec");
        chk(ea === 32'd3796, "R5 literal", ea, 32'd3796);
        chk(rd_data === 32'd3796, "R5 base literal", rd_data, 32'd3796);
        // R6 post-increment
        load(3'd2, 32'd3800);
        op(3'd3, 3'd2, 3'd0, 16'd0, "R6 postinc");
        chk(ea === 32'd3800, "R6 literal", ea, 32'd3800);
        chk(rd_data === 32'd3804, "R6 base literal", rd_data, 32'd3804);
        // R7 no strobe without start
        @(negedge clk);
        chk(ea_valid === 1'b0, "R7 idle", 32'(ea_valid), 0);
        // R9 negative displacement and wrap
        load(3'd3, 32'd3800);
        op(3'd0, 3'd3, 3'd0, 16'hFFFC, "R9 neg disp");
        load(3'd4, 32'hFFFF_FFFE);
        op(3'd3, 3'd4, 3'd0, 16'd0, "R9 wrap postinc");
        chk(rd_data === 32'h2, "R9 wrap base", rd_data, 32'h2);
        load(3'd5, 32'h0);
        op(3'd2, 3'd5, 3'd0, 16'd0, "R9 wrap predec");
        chk(ea === 32'hFFFF_FFFC, "R9 wrap ea", ea, 32'hFFFF_FFFC);
        op(3'd1, 3'd4, 3'd4, 16'h8000, "R9 index min disp");
        // R8 illegal codes leave registers untouched
        for (int c = 4; c < 8; c++) begin
            op(3'(c), 3'd2, 3'd1, 16'h1234, "R8 illegal");
            for (int k = 0; k < 8; k++) peek(3'(k), "R8 regs unchanged");
        end
        // R10 load beats write-back
        op(3'd3, 3'd6, 3'd0, 16'd0, "R10 postinc+load", 1, 3'd6, 32'hCAFE_0000);
        chk(rd_data === 32'hCAFE_0000, "R10 literal", rd_data, 32'hCAFE_0000);
        // R11 back-to-back post-increments
        load(3'd7, 32'h1000);
        op(3'd3, 3'd7, 3'd0, 16'd0, "R11 first");
        chk(ea === 32'h1000, "R11 first ea", ea, 32'h1000);
        op(3'd3, 3'd7, 3'd0, 16'd0, "R11 second");
        chk(ea === 32'h1004, "R11 second ea", ea, 32'h1004);
        op(3'd2, 3'd7, 3'd0, 16'd0, "R11 third predec");
        chk(ea === 32'h1004, "R11 third ea", ea, 32'h1004);

        // Random mix of all codes (R3 R4 R5 R6 R8 R9)
        for (int k = 0; k < 8; k++) load(3'(k), $urandom);
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            m = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
            op(m, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               16'($urandom), "random");
            if ((n % 50) == 0) begin
                @(negedge clk);
                chk(ea_valid === 1'b0, "R7 random idle", 32'(ea_valid), 0);
            end
        end
        for (int k = 0; k < 8; k++) peek(3'(k), "final regs");
        finish_run();
    end

endmodule